// File: doc/BRIEF.md
# Program-Space Bus Cycle Stretcher

This block lengthens bus cycles to off-chip program memory so that slow devices have time to respond. Software writes a 16-bit control word. Two 3-bit fields in that word set the number of wait cycles. One field covers the low half of program space and the other covers the high half. When the core starts an access, the block looks at the top address bit, picks the matching field and holds the core stalled while it counts that many wait cycles down.

After the count runs out, the block checks an external ready line once in every cycle. A low ready level keeps the access open for another cycle, and there is no upper bound on how many cycles that can add. While the access lasts, the block drives an active-low program-select strobe. For reads it also drives an active-low read strobe, which is steady enough to feed a memory's output-enable pin directly. A one-cycle done pulse marks the final cycle of each access.

Top module: `pbus_wait_gen`

## Requirements
- R1: After reset, ps_n and rd_n are 1 and stall and done are 0. Both wait fields hold 7, so before any configuration write an access in either half lasts 8 cycles.
- R2: Control bits 2:0 give the wait count N for addresses with bit 15 = 0. With ready high, such an access lasts N+1 cycles. stall is 1 in the first N cycles and 0 in the last, and done is 1 only in the last.
- R3: Control bits 5:3 give the wait count for addresses with bit 15 = 1, with the same timing as R2.
- R4: The programmed count applies equally to reads (req_write = 0) and writes (req_write = 1).
- R5: ps_n is 0 in every cycle of an access and 1 in every idle cycle.
- R6: rd_n is 0 in every cycle of a read access. It is 1 in every cycle of a write access and in every idle cycle.
- R7: ready_i is ignored during the programmed wait cycles. A low level there does not lengthen the access.
- R8: Once the count has expired, each cycle with ready_i = 0 adds one cycle, with stall held at 1 and done held at 0. This has no limit. The access ends in the first such cycle with ready_i = 1.
- R9: A control write made during an access does not change that access. It applies from the next access onward.
- R10: A request presented while an access is in progress is ignored. The cycle after done is always idle (ps_n = 1).
- R11: done is a single-cycle pulse per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Control register write enable |
| cfg_wdata | input | 16 | Control word; bits 2:0 low-half waits, bits 5:3 high-half waits, rest ignored |
| req_valid | input | 1 | Core requests an off-chip program access (accepted when idle) |
| req_addr | input | 16 | Program address; bit 15 selects the wait field |
| req_write | input | 1 | 1 = write access, 0 = read access |
| ready_i | input | 1 | External ready, checked each cycle after the wait count expires |
| ps_n | output | 1 | Active-low program-select strobe |
| rd_n | output | 1 | Active-low read strobe |
| stall | output | 1 | Holds the core while the access is not in its final cycle |
| done | output | 1 | High in the final cycle of an access |

## Verification
The bench measures access length for both address halves and for the extreme counts 0 and 7. A design that picked the wrong field, or that counted N or N+2 cycles, would fail the cycle-length check. Ready is driven low during the wait cycles to catch a design that samples it too early. It is also held low for several cycles after expiry, which shows a design that gives up after one extension or drops stall too soon. A control write in the middle of an access and a request held high through done target designs that read the register live or that re-enter an access with no idle cycle between them.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
  parameter int unsigned ADDR_W = 16;
  parameter int unsigned DATA_W = 16;
  parameter int unsigned WAIT_W = 3;
  parameter int unsigned LO_LSB = 0;
  parameter int unsigned HI_LSB = 3;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACCESS = 1'b1
  } pbw_state_e;

  // Pick the wait count for a given address half.
  function automatic logic [WAIT_W-1:0] pick_wait(
    input logic [WAIT_W-1:0] lo_wait,
    input logic [WAIT_W-1:0] hi_wait,
    input logic              upper_half
  );
    return upper_half ? hi_wait : lo_wait;
  endfunction

  // Total access length with ready always high.
  function automatic int unsigned access_len(input logic [WAIT_W-1:0] n);
    return int'(n) + 1;
  endfunction
endpackage

// File: rtl/pbw_cfg_reg.sv
module pbw_cfg_reg #(
  parameter int unsigned DATA_W = pbw_pkg::DATA_W,
  parameter int unsigned WAIT_W = pbw_pkg::WAIT_W,
  parameter int unsigned LO_LSB = pbw_pkg::LO_LSB,
  parameter int unsigned HI_LSB = pbw_pkg::HI_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  output logic [WAIT_W-1:0] lo_wait,
  output logic [WAIT_W-1:0] hi_wait
);
  localparam logic [WAIT_W-1:0] WAIT_MAX = {WAIT_W{1'b1}};

  logic [WAIT_W-1:0] lo_q;
  logic [WAIT_W-1:0] hi_q;
  logic              unused_cfg_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q <= WAIT_MAX;
      hi_q <= WAIT_MAX;
    end else if (we) begin
      lo_q <= wdata[LO_LSB +: WAIT_W];
      hi_q <= wdata[HI_LSB +: WAIT_W];
    end
  end

  assign lo_wait = lo_q;
  assign hi_wait = hi_q;
  assign unused_cfg_bits = ^wdata;
endmodule

// File: rtl/pbw_seq.sv
module pbw_seq #(
  parameter int unsigned ADDR_W = pbw_pkg::ADDR_W,
  parameter int unsigned WAIT_W = pbw_pkg::WAIT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              ready_i,
  input  logic [WAIT_W-1:0] lo_wait,
  input  logic [WAIT_W-1:0] hi_wait,
  output logic              busy,
  output logic              cur_write,
  output logic              acc_start,
  output logic              wait_expired,
  output logic              acc_end
);
  import pbw_pkg::*;

  localparam int unsigned SEL_BIT = ADDR_W - 1;

  pbw_state_e        state_q;
  logic [WAIT_W-1:0] cnt_q;
  logic              write_q;
  logic [WAIT_W-1:0] start_cnt;
  logic              unused_addr_bits;

  assign start_cnt        = pick_wait(lo_wait, hi_wait, req_addr[SEL_BIT]);
  assign unused_addr_bits = ^req_addr[SEL_BIT-1:0];

  assign busy         = (state_q == ST_ACCESS);
  assign acc_start    = (state_q == ST_IDLE) && req_valid;
  assign wait_expired = busy && (cnt_q == '0);
  assign acc_end      = wait_expired && ready_i;
  assign cur_write    = write_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      write_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (acc_start) begin
            state_q <= ST_ACCESS;
            cnt_q   <= start_cnt;
            write_q <= req_write;
          end
        end
        ST_ACCESS: begin
          if (!wait_expired) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (ready_i) begin
            state_q <= ST_IDLE;
            write_q <= 1'b0;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pbw_strobe.sv
module pbw_strobe (
  input  logic busy,
  input  logic cur_write,
  input  logic acc_end,
  output logic ps_n,
  output logic rd_n,
  output logic stall,
  output logic done
);
  assign ps_n  = ~busy;
  assign rd_n  = ~(busy & ~cur_write);
  assign stall = busy & ~acc_end;
  assign done  = acc_end;
endmodule

// File: rtl/pbus_wait_gen.sv
module pbus_wait_gen #(
  parameter int unsigned ADDR_W = pbw_pkg::ADDR_W,
  parameter int unsigned DATA_W = pbw_pkg::DATA_W,
  parameter int unsigned WAIT_W = pbw_pkg::WAIT_W,
  parameter int unsigned LO_LSB = pbw_pkg::LO_LSB,
  parameter int unsigned HI_LSB = pbw_pkg::HI_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              ready_i,
  output logic              ps_n,
  output logic              rd_n,
  output logic              stall,
  output logic              done
);
  logic [WAIT_W-1:0] lo_wait;
  logic [WAIT_W-1:0] hi_wait;
  logic              busy;
  logic              cur_write;
  logic              acc_start;
  logic              wait_expired;
  logic              acc_end;

  pbw_cfg_reg #(
    .DATA_W(DATA_W), .WAIT_W(WAIT_W), .LO_LSB(LO_LSB), .HI_LSB(HI_LSB)
  ) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .wdata  (cfg_wdata),
    .lo_wait(lo_wait),
    .hi_wait(hi_wait)
  );

  pbw_seq #(
    .ADDR_W(ADDR_W), .WAIT_W(WAIT_W)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_addr    (req_addr),
    .req_write   (req_write),
    .ready_i     (ready_i),
    .lo_wait     (lo_wait),
    .hi_wait     (hi_wait),
    .busy        (busy),
    .cur_write   (cur_write),
    .acc_start   (acc_start),
    .wait_expired(wait_expired),
    .acc_end     (acc_end)
  );

  pbw_strobe u_strobe (
    .busy     (busy),
    .cur_write(cur_write),
    .acc_end  (acc_end),
    .ps_n     (ps_n),
    .rd_n     (rd_n),
    .stall    (stall),
    .done     (done)
  );
endmodule

// File: rtl/pbw_chk.sv
module pbw_chk (
  input logic clk,
  input logic rst_n,
  input logic ready_i,
  input logic ps_n,
  input logic rd_n,
  input logic stall,
  input logic done,
  input logic acc_start,
  input logic wait_expired
);
  // R5
  stall_in_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !ps_n);

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  idle_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ps_n);

  // R8
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_expired && !ready_i) |-> (stall && !done));

  // R7
  no_early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ps_n && !wait_expired) |-> (stall && !done));

  // R6
  rd_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ps_n && $past(!ps_n)) |-> $stable(rd_n));

  // R6
  rd_needs_ps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !ps_n);

  // R2
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_start |=> !ps_n);
endmodule

bind pbus_wait_gen pbw_chk u_pbw_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ready_i     (ready_i),
  .ps_n        (ps_n),
  .rd_n        (rd_n),
  .stall       (stall),
  .done        (done),
  .acc_start   (acc_start),
  .wait_expired(wait_expired)
);

// File: tb/test_pbus_wait_gen.sv
`timescale 1ns/1ps
module test_pbus_wait_gen;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        ready_i = 1'b1;
  logic        ps_n, rd_n, stall, done;

  int n_total = 0;
  int n_fail  = 0;

  int got_cycles, stall_bad, ps_bad, rd_bad, done_cnt;
  logic idle_ps;

  always #4 clk = ~clk;

  pbus_wait_gen i_pbus_wait_gen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
    .ready_i(ready_i), .ps_n(ps_n), .rd_n(rd_n), .stall(stall), .done(done)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [2:0] lo, input logic [2:0] hi);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_wdata = {10'h3A5, hi, lo};
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // Runs one access; ready is 'wait_rdy' during the first exp_wait cycles,
  // then 0 for extra_low cycles, then 1.
  task automatic run_access(input logic [15:0] a, input logic w, input int exp_wait,
                            input logic wait_rdy, input int extra_low,
                            input logic hold_req, input logic mid_cfg,
                            input logic [15:0] mid_val);
    int cyc;
    cyc = 200;
    stall_bad = 0; ps_bad = 0; rd_bad = 0; done_cnt = 0;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; ready_i = 1'b1;
    for (int i = 1; i <= 200; i++) begin
      @(negedge clk);
      if (!hold_req) req_valid = 1'b0;
      cfg_we    = mid_cfg && (i == 1);
      cfg_wdata = mid_val;
      ready_i   = (i <= exp_wait) ? wait_rdy : ((i <= exp_wait + extra_low) ? 1'b0 : 1'b1);
      #1;
      if (ps_n !== 1'b0) ps_bad++;
      if (rd_n !== w) rd_bad++;
      if (done === 1'b1) begin
        done_cnt++;
        if (stall !== 1'b0) stall_bad++;
        cyc = i;
        break;
      end else if (stall !== 1'b1) begin
        stall_bad++;
      end
    end
    cfg_we = 1'b0; req_valid = 1'b0; ready_i = 1'b1;
    @(negedge clk);
    #1;
    idle_ps = ps_n;
    if (done === 1'b1) done_cnt++;
    got_cycles = cyc;
  endtask

  task automatic check_access(input string req, input logic w, input int exp_len);
    chk(req, "access length", got_cycles, exp_len);
    chk(req, "stall pattern errors", stall_bad, 0);
    chk("R5", "ps_n high inside access", ps_bad, 0);
    chk("R6", "rd_n mismatch inside access", rd_bad, 0);
    chk("R11", "done pulses", done_cnt, 1);
    chk("R10", "ps_n in cycle after done", int'(idle_ps), 1);
  endtask

  task automatic test_reset;
    #1;
    chk("R1", "ps_n at reset", int'(ps_n), 1);
    chk("R1", "rd_n at reset", int'(rd_n), 1);
    chk("R1", "stall at reset", int'(stall), 0);
    chk("R1", "done at reset", int'(done), 0);
    run_access(16'h0123, 1'b0, 7, 1'b1, 0, 1'b0, 1'b0, '0);
    check_access("R1", 1'b0, 8);
    run_access(16'hF000, 1'b0, 7, 1'b1, 0, 1'b0, 1'b0, '0);
    check_access("R1", 1'b0, 8);
  endtask

  task automatic test_lower;
    write_cfg(3'd2, 3'd5);
    run_access(16'h7FFF, 1'b0, 2, 1'b1, 0, 1'b0, 1'b0, '0);
    check_access("R2", 1'b0, 3);
    write_cfg(3'd0, 3'd5);
    run_access(16'h0000, 1'b0, 0, 1'b1, 0, 1'b0, 1'b0, '0);
    check_access("R2", 1'b0, 1);
  endtask

  task automatic test_upper;
    write_cfg(3'd1, 3'd4);
    run_access(16'h8000, 1'b0, 4, 1'b1, 0, 1'b0, 1'b0, '0);
    check_access("R3", 1'b0, 5);
    write_cfg(3'd6, 3'd0);
    run_access(16'hFFFF, 1'b0, 0, 1'b1, 0, 1'b0, 1'b0, '0);
    check_access("R3", 1'b0, 1);
  endtask

  task automatic test_write;
    write_cfg(3'd3, 3'd6);
    run_access(16'h1234, 1'b1, 3, 1'b1, 0, 1'b0, 1'b0, '0);
    check_access("R4", 1'b1, 4);
    run_access(16'hC000, 1'b1, 6, 1'b1, 0, 1'b0, 1'b0, '0);
    check_access("R4", 1'b1, 7);
  endtask

  task automatic test_ready_in_wait;
    write_cfg(3'd4, 3'd2);
    run_access(16'h0040, 1'b0, 4, 1'b0, 0, 1'b0, 1'b0, '0);
    check_access("R7", 1'b0, 5);
  endtask

  task automatic test_ready_extend;
    write_cfg(3'd1, 3'd2);
    run_access(16'h9000, 1'b0, 2, 1'b1, 5, 1'b0, 1'b0, '0);
    check_access("R8", 1'b0, 8);
    run_access(16'h0001, 1'b1, 1, 1'b1, 12, 1'b0, 1'b0, '0);
    check_access("R8", 1'b1, 14);
  endtask

  task automatic test_cfg_mid;
    write_cfg(3'd2, 3'd2);
    run_access(16'h0100, 1'b0, 2, 1'b1, 0, 1'b0, 1'b1, 16'h0005);
    check_access("R9", 1'b0, 3);
    run_access(16'h0100, 1'b0, 5, 1'b1, 0, 1'b0, 1'b0, '0);
    check_access("R9", 1'b0, 6);
  endtask

  task automatic test_busy_req;
    write_cfg(3'd3, 3'd1);
    run_access(16'h0200, 1'b0, 3, 1'b1, 0, 1'b1, 1'b0, '0);
    check_access("R10", 1'b0, 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    test_reset();
    test_lower();
    test_upper();
    test_write();
    test_ready_in_wait();
    test_ready_extend();
    test_cfg_mid();
    test_busy_req();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end
endmodule